// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral on a 32-bit register bus. Software configures it through one control word that is write-protected: a write lands only when it is the second half of an exact two-write key sequence. The first write carries one key byte, and the next write carries the second key byte together with the new configuration. One sequence does every job. It starts the timer, stops it, or kicks it, because completing the sequence always reloads the down-counter from the new reload value.

The down-counter steps once per prescaled tick. A pre-warning output goes high when the count drops to or below a selectable fraction of the full 16-bit period. When the count sits at zero while the timer runs, the block raises a one-cycle reset request and stops itself. It also sets a reset-cause flag that stays set until the next power-on reset. A read-only status word shows whether the timer runs and gives the live count.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset (`rst_n` low), both readable words are zero and `prewarn`, `rst_req` and `rst_cause` are low.
- R2: A write to offset 0x0 with 0xBE in bits 23:16 arms the key logic. If the next bus write also goes to offset 0x0 and carries 0xDC in bits 23:16, it commits bits 31:24 and 15:0. Offset 0x0 then reads back those bits with bits 23:16 as zero.
- R3: The following writes change nothing: a write with a wrong key, a second key with no first key before it, a write to any other offset between the two key writes, or a repeated first key. Each such write returns the key logic to idle.
- R4: Offset 0x8 reads {running, 15'b0, count}. A commit loads the count from bits 15:0, restarts the prescaler, and sets running to bit 31.
- R5: Bits 25:24 pick the tick divider D = 2^SHn (defaults 1, 64, 4096, 262144). After a commit at cycle 0, the count at cycle k is N - floor(k/D), down to zero.
- R6: The cycle after the count reads zero while running, `rst_req` is high for exactly one cycle and running clears. With reload N this is cycle N*D+1 after the commit.
- R7: `rst_cause` sets with the reset request and stays set until the next `rst_n`.
- R8: `prewarn` is high exactly while running and count <= 0x8000 >> S, where S is bits 27:26 (1/2, 1/4, 1/8 and 1/16 of the full period).
- R9: A commit with bit 31 clear stops the timer. The count holds the new reload value and no reset request follows.
- R10: A commit while running reloads the count and postpones expiry by the full new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| prewarn | output | 1 | Pre-warning level |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_cause | output | 1 | Sticky flag: the watchdog caused a reset |

## Verification
The commit takes effect at the clock edge that samples the second key write. Reads are combinational, so the bench samples status at the falling edge after that write and calls it cycle 0. From there the count is due at N - floor(k/D) at cycle k. The reset request is due at cycle N*D+1 and is low again one cycle later. The bench compares the count, `prewarn` and `rst_req` at every falling edge of that window, using a reduced divider set (1, 2, 4, 8) so all divider and reload pairs fit in a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W = 16;
  localparam logic [7:0] KEY_FIRST  = 8'hBE;
  localparam logic [7:0] KEY_SECOND = 8'hDC;

  // stored control fields, laid out as bits 31:24 and 15:0 of the word
  typedef struct packed {
    logic             en;
    logic [2:0]       spare;
    logic [1:0]       warn_sel;
    logic [1:0]       div_sel;
    logic [CNT_W-1:0] reload;
  } wdt_cfg_t;

  // pre-warning level: half of the full period, shifted down by sel
  function automatic logic [CNT_W-1:0] warn_level(input logic [1:0] sel);
    return (CNT_W'(1) << (CNT_W - 1)) >> sel;
  endfunction

  // terminal value of the prescaler for a 2^sh divider
  function automatic logic [31:0] div_limit(input int unsigned sh);
    return (32'd1 << sh) - 32'd1;
  endfunction
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       is_ctrl,
  input  logic [7:0] key,
  output logic       commit
);
  logic armed_q;
  logic arm_hit;

  always_comb begin
    arm_hit = we && is_ctrl && (key == KEY_FIRST) && !armed_q;
    commit  = we && is_ctrl && (key == KEY_SECOND) && armed_q;
  end

  // every write leaves the armed state; only a fresh first key enters it
  always_ff @(posedge clk) begin
    if (!rst_n)  armed_q <= 1'b0;
    else if (we) armed_q <= arm_hit;
  end

  AST_ARM_NEEDS_KEY1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(we && is_ctrl && key == KEY_FIRST)); // R2
  AST_COMMIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !armed_q); // R3
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned SH0 = 0,
  parameter int unsigned SH1 = 6,
  parameter int unsigned SH2 = 12,
  parameter int unsigned SH3 = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int unsigned M01   = (SH0 > SH1) ? SH0 : SH1;
  localparam int unsigned M23   = (SH2 > SH3) ? SH2 : SH3;
  localparam int unsigned MAXSH = (M01 > M23) ? M01 : M23;
  localparam int unsigned PSC_W = MAXSH + 1;

  logic [PSC_W-1:0] pre_q;
  logic [PSC_W-1:0] limit;

  always_comb begin
    case (div_sel)
      2'd0:    limit = PSC_W'(div_limit(SH0));
      2'd1:    limit = PSC_W'(div_limit(SH1));
      2'd2:    limit = PSC_W'(div_limit(SH2));
      default: limit = PSC_W'(div_limit(SH3));
    endcase
    tick = run && (pre_q == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              pre_q <= '0;
    else if (clear || !run)  pre_q <= '0;
    else if (tick)           pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pre_q <= limit); // R5
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             req,
  output logic             cause
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, req_q, cause_q;
  logic             expire;

  assign expire = run_q && (cnt_q == '0) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      req_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      req_q <= expire;
      if (expire) cause_q <= 1'b1;
      if (load) begin
        cnt_q <= load_val;
        run_q <= load_en;
      end else if (expire) begin
        run_q <= 1'b0;
      end else if (run_q && tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt     = cnt_q;
  assign running = run_q;
  assign req     = req_q;
  assign cause   = cause_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R6
  AST_REQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !run_q); // R6
  AST_REQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(run_q && cnt_q == '0)); // R6
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q |=> cause_q); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DIV_SH0 = 0,
  parameter int unsigned DIV_SH1 = 6,
  parameter int unsigned DIV_SH2 = 12,
  parameter int unsigned DIV_SH3 = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              prewarn,
  output logic              rst_req,
  output logic              rst_cause
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(8);

  wdt_cfg_t         cfg_q;
  logic             is_ctrl, commit, tick, running;
  logic [CNT_W-1:0] cnt;

  assign is_ctrl = (bus_addr == CTRL_OFS);

  wdt_unlock i_unlock (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .is_ctrl(is_ctrl),
    .key(bus_wdata[23:16]), .commit(commit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (commit) cfg_q <= {bus_wdata[31:24], bus_wdata[15:0]};
  end

  wdt_prescaler #(.SH0(DIV_SH0), .SH1(DIV_SH1), .SH2(DIV_SH2), .SH3(DIV_SH3))
  i_prescaler (
    .clk(clk), .rst_n(rst_n), .clear(commit), .run(running),
    .div_sel(cfg_q.div_sel), .tick(tick)
  );

  wdt_counter i_counter (
    .clk(clk), .rst_n(rst_n), .load(commit), .load_en(bus_wdata[31]),
    .load_val(bus_wdata[15:0]), .tick(tick), .cnt(cnt),
    .running(running), .req(rst_req), .cause(rst_cause)
  );

  assign prewarn = running && (cnt <= warn_level(cfg_q.warn_sel));

  always_comb begin
    if (bus_addr == CTRL_OFS)      bus_rdata = {cfg_q[23:16], 8'h00, cfg_q.reload};
    else if (bus_addr == STAT_OFS) bus_rdata = {running, 15'b0, cnt};
    else                           bus_rdata = '0;
  end

  AST_WARN_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(prewarn)); // R8
  AST_CFG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_q)); // R3
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        prewarn, rst_req, rst_cause;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.ADDR_W(4), .DIV_SH0(0), .DIV_SH1(1), .DIV_SH2(2), .DIV_SH3(3))
  i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .prewarn(prewarn), .rst_req(rst_req), .rst_cause(rst_cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic commit(input logic [31:0] cfg);
    wr(4'h0, 32'h00BE_0000);
    wr(4'h0, (cfg & 32'hFF00_FFFF) | 32'h00DC_0000);
  endtask

  function automatic logic [31:0] stat(input logic run, input logic [15:0] c);
    return {run, 15'b0, c};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
    rd(4'h8, v); chk("R1 status", v, 32'h0);
    chk("R1 outputs", {29'b0, prewarn, rst_req, rst_cause}, 32'h0);

    // R5 R6 sweep over dividers and reloads
    for (int ps = 0; ps < 4; ps++) begin
      for (int n = 1; n <= 4; n++) begin
        int d;
        d = 1 << ps;
        commit(32'h8C00_0000 | (ps << 24) | n);
        for (int k = 0; k <= n * d + 2; k++) begin
          logic [15:0] ec;
          logic er;
          if (k > 0) @(negedge clk);
          ec = (k >= n * d) ? 16'd0 : 16'(n - k / d);
          er = (k <= n * d);
          rd(4'h8, v);
          chk("R5 count", v, stat(er, ec));
          chk("R6 request", {31'b0, rst_req}, {31'b0, (k == n * d + 1)});
          chk("R8 warn sel3", {31'b0, prewarn}, {31'b0, er});
        end
        chk("R7 cause set", {31'b0, rst_cause}, 32'd1);
      end
    end

    // R2 commit and readback
    commit(32'hF5AB_1234);
    rd(4'h0, v); chk("R2 readback", v, 32'hF500_1234);
    // R3 broken sequences
    wr(4'h0, 32'h00BE_0000); wr(4'h0, 32'h00DD_0005);
    rd(4'h0, v); chk("R3 wrong key", v, 32'hF500_1234);
    wr(4'h0, 32'h00DC_0006);
    rd(4'h0, v); chk("R3 no first key", v, 32'hF500_1234);
    wr(4'h0, 32'h00BE_0000); wr(4'h8, 32'h0); wr(4'h0, 32'h00DC_0007);
    rd(4'h0, v); chk("R3 other offset", v, 32'hF500_1234);
    wr(4'h0, 32'h00BE_0000); wr(4'h0, 32'h00BE_0000); wr(4'h0, 32'h00DC_0008);
    rd(4'h0, v); chk("R3 repeated key1", v, 32'hF500_1234);
    rd(4'h8, v); chk("R3 count not reloaded", {31'b0, v[31] && (v[15:0] > 16'h1000)}, 32'd1);

    // R9 stop
    commit(32'h0000_0007);
    rd(4'h0, v); chk("R9 ctrl", v, 32'h0000_0007);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      rd(4'h8, v); chk("R9 holds", v, stat(1'b0, 16'd7));
      chk("R9 no request", {30'b0, rst_req, prewarn}, 32'd0);
    end

    // R10 kick
    commit(32'h8C00_000A);
    repeat (5) @(negedge clk);
    rd(4'h8, v); chk("R10 before kick", v, stat(1'b1, 16'd5));
    commit(32'h8C00_000A);
    for (int k = 0; k <= 12; k++) begin
      if (k > 0) @(negedge clk);
      rd(4'h8, v);
      chk("R10 count", v, stat(k <= 10, (k >= 10) ? 16'd0 : 16'(10 - k)));
      chk("R10 request", {31'b0, rst_req}, {31'b0, (k == 11)});
    end

    // R8 thresholds
    for (int s = 0; s < 4; s++) begin
      logic [15:0] t;
      t = 16'h8000 >> s;
      commit(32'h8000_0000 | (s << 26) | (t + 16'd2));
      for (int k = 0; k < 4; k++) begin
        if (k > 0) @(negedge clk);
        chk("R8 warn", {31'b0, prewarn}, {31'b0, (k >= 2)});
      end
      commit(32'h0000_0000);
      chk("R8 idle", {31'b0, prewarn}, 32'd0);
    end

    // R4 status layout with a running timer, then R7 clear by reset
    commit(32'h8300_0100);
    rd(4'h8, v); chk("R4 status", v, 32'h8000_0100);
    chk("R7 still set", {31'b0, rst_cause}, 32'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R7 cleared", {31'b0, rst_cause}, 32'd0);
    rd(4'h8, v); chk("R1 status after reset", v, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule